// File: doc/BRIEF.md
# Address Translation Cache with Address-Space Tags

This block is a small, fully associative store of virtual-to-physical page translations. On a lookup, every entry compares its stored virtual page number and address-space tag against the request at the same time. The result comes back one clock after the request. It gives the physical page number, the entry's access right, the entry's usage bits and a protection-fault flag. Because each entry is tagged with an address-space identifier, entries from several processes can sit side by side, and a context switch only needs a new value on the current-identifier input.

A table walker loads new translations through the fill port. A fill that names a page and identifier already present overwrites that entry. Otherwise the fill takes a free slot, and only when no slot is free does it evict the slot chosen by a tree pseudo-LRU. Software removes stale mappings through the invalidate port, either one translation by page and identifier, or all of them at once. Every hit marks its entry as referenced. A write hit on a writable entry marks it dirty. A write hit on a read-only entry is reported as a fault and leaves the entry clean.

Top module: `xlat_cache`

## Requirements
- R1: After reset no entry is valid, `rsp_valid` is 0, and any lookup misses.
- R2: A lookup request in cycle N produces `rsp_valid`=1 in cycle N+1. On a hit, that response carries `rsp_hit`=1, the stored physical page and the stored access right (`rsp_rw`: 1 = read/write, 0 = read-only).
- R3: A lookup hits only an entry whose identifier equals `cur_asid`. Two entries with the same virtual page and different identifiers coexist, and each returns its own physical page.
- R4: `rsp_ref` and `rsp_dirty` report the entry's bits as they were before the access. Any hit sets the referenced bit, so a fresh fill reports `rsp_ref`=0 on its first hit and 1 on later hits.
- R5: A write hit on a read/write entry sets its dirty bit; the next lookup of that entry reports `rsp_dirty`=1. A new fill starts with both usage bits clear.
- R6: A write hit on a read-only entry gives `rsp_fault`=1 with `rsp_hit`=1 and leaves the dirty bit clear. A read hit on a read-only entry gives no fault.
- R7: A fill whose page and identifier match a valid entry overwrites that entry in place and uses no extra slot.
- R8: A fill into a structure that still has an invalid slot uses the lowest-numbered invalid slot and evicts nothing.
- R9: When all slots are valid, the fill evicts the slot selected by a binary tree of ENTRIES-1 bits. Each bit points to the less recently touched half. Hits and fills touch the tree by making each node on the slot's path point away from that slot.
- R10: A single invalidation removes only the valid entry whose page and identifier both match. Entries with the same page under another identifier stay.
- R11: A global invalidation clears every entry; lookups in later cycles miss.
- R12: A miss response has `rsp_hit`=0 and `rsp_ppn`, `rsp_rw`, `rsp_ref`, `rsp_dirty` and `rsp_fault` all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cur_asid | input | ASID_W | Identifier of the running address space |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Virtual page to translate |
| lk_write | input | 1 | Lookup is for a store |
| rsp_valid | output | 1 | Response present (one cycle after request) |
| rsp_hit | output | 1 | Translation found |
| rsp_ppn | output | PPN_W | Physical page on hit |
| rsp_rw | output | 1 | Entry is writable |
| rsp_ref | output | 1 | Referenced bit before this access |
| rsp_dirty | output | 1 | Dirty bit before this access |
| rsp_fault | output | 1 | Write to a read-only page |
| fill_valid | input | 1 | Load a translation |
| fill_vpn | input | VPN_W | Virtual page of the fill |
| fill_ppn | input | PPN_W | Physical page of the fill |
| fill_asid | input | ASID_W | Identifier of the fill |
| fill_rw | input | 1 | Access right of the fill (1 = read/write) |
| inv_one | input | 1 | Invalidate one translation |
| inv_vpn | input | VPN_W | Page to invalidate |
| inv_asid | input | ASID_W | Identifier to invalidate |
| inv_all | input | 1 | Invalidate everything |

## Verification
The hardest state to reach from the ports is a full structure in which the replacement tree points at a known slot. Only then does a fill show which entry it evicts. The bench first clears everything, fills all sixteen slots in order, and then hits one chosen page. This gives a tree whose victim can be worked out by hand. After one more fill, it probes the expected victim and its neighbours to confirm that exactly one translation disappeared. The bench then punches a single hole with a targeted invalidation, which shows that the next fill prefers that hole over the tree's choice.

// File: rtl/xlat_pkg.sv
// Shared definitions for the translation cache.
// Assumes: nothing beyond standard SystemVerilog.
package xlat_pkg;

    // Access right stored with every translation.
    typedef enum logic {
        ACC_RO = 1'b0,
        ACC_RW = 1'b1
    } acc_e;

    // Default geometry shared by the top and its helpers.
    localparam int unsigned XL_ENTRIES = 16;
    localparam int unsigned XL_VPN_W   = 20;
    localparam int unsigned XL_PPN_W   = 20;
    localparam int unsigned XL_ASID_W  = 8;

endpackage

// File: rtl/xlat_match.sv
// Parallel tag compare: one comparator per entry on page number and
// address-space identifier, gated by the entry's valid bit.
// Assumes: caller keeps at most one valid entry per (page, identifier).
module xlat_match #(
    parameter int unsigned N      = 16,
    parameter int unsigned VPN_W  = 20,
    parameter int unsigned ASID_W = 8
) (
    input  logic [N-1:0]             ent_valid,
    input  logic [N-1:0][VPN_W-1:0]  ent_vpn,
    input  logic [N-1:0][ASID_W-1:0] ent_asid,
    input  logic [VPN_W-1:0]         key_vpn,
    input  logic [ASID_W-1:0]        key_asid,
    output logic [N-1:0]             hit_vec
);

    // One comparator per entry, all evaluated at once.
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign hit_vec[g] = ent_valid[g]
                         && (ent_vpn[g]  == key_vpn)
                         && (ent_asid[g] == key_asid);
    end

endmodule

// File: rtl/xlat_enc.sv
// Priority encoder: returns the lowest set bit of a request vector and
// whether any bit is set.
// Assumes: N is at least 2.
module xlat_enc #(
    parameter int unsigned N = 16,
    localparam int unsigned IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     req,
    output logic             any,
    output logic [IDX_W-1:0] idx
);

    // Scan from the top so the lowest set bit is the last assignment.
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IDX_W'(i);
        end
        any = |req;
    end

endmodule

// File: rtl/xlat_plru.sv
// Tree pseudo-LRU replacement state. Node k (heap numbering from 1) is
// held in bit k-1. A 0 bit selects the lower half, a 1 the upper.
// Touching a slot makes every node on its path point to the other half.
// Two touches per cycle are applied in order a then b.
// Assumes: N is a power of two and at least 4.
module xlat_plru #(
    parameter int unsigned N = 16,
    localparam int unsigned IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             touch_a,
    input  logic [IDX_W-1:0] touch_a_idx,
    input  logic             touch_b,
    input  logic [IDX_W-1:0] touch_b_idx,
    output logic [IDX_W-1:0] victim_idx
);

    logic [N-2:0] tree_q;
    logic [N-2:0] tree_d;

    // Mark one slot as most recently used along its root-to-leaf path.
    function automatic logic [N-2:0] touch_path(input logic [N-2:0] t,
                                                input logic [IDX_W-1:0] slot);
        logic [N-2:0]     r;
        logic [IDX_W:0]   node;
        logic [IDX_W-1:0] rem;
        logic             dir;
        r    = t;
        node = (IDX_W+1)'(1);
        rem  = slot;
        for (int lvl = 0; lvl < IDX_W; lvl++) begin
            dir = rem[IDX_W-1];
            r[IDX_W'(node - 1'b1)] = ~dir;
            node = {node[IDX_W-1:0], dir};
            rem  = rem << 1;
        end
        return r;
    endfunction

    // Next tree state from the two touch requests.
    always_comb begin
        tree_d = tree_q;
        if (touch_a) tree_d = touch_path(tree_d, touch_a_idx);
        if (touch_b) tree_d = touch_path(tree_d, touch_b_idx);
    end

    // Follow the pointers from the root to pick the victim slot.
    always_comb begin
        logic [IDX_W:0] node;
        node = (IDX_W+1)'(1);
        for (int lvl = 0; lvl < IDX_W; lvl++) begin
            node = {node[IDX_W-1:0], tree_q[IDX_W'(node - 1'b1)]};
        end
        victim_idx = node[IDX_W-1:0];
    end

    // Replacement state register.
    always_ff @(posedge clk) begin
        if (!rst_n) tree_q <= '0;
        else        tree_q <= tree_d;
    end

endmodule

// File: rtl/xlat_cache.sv
// Fully associative translation cache tagged by address-space identifier.
// Lookup: compared against every entry at once, response registered one
// cycle later. Usage bits in the response are the values before the access.
// Fill: overwrite matching entry, else lowest invalid slot, else tree-PLRU
// victim. Update priority per entry: global invalidate, single invalidate,
// fill, then usage-bit update from a lookup hit.
// Assumes: at most one request of each kind per cycle; a fill in the same
// cycle as a global invalidation is dropped.
module xlat_cache
    import xlat_pkg::*;
#(
    parameter int unsigned ENTRIES = XL_ENTRIES,
    parameter int unsigned VPN_W   = XL_VPN_W,
    parameter int unsigned PPN_W   = XL_PPN_W,
    parameter int unsigned ASID_W  = XL_ASID_W,
    localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ASID_W-1:0] cur_asid,
    input  logic              lk_valid,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic              lk_write,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [PPN_W-1:0]  rsp_ppn,
    output logic              rsp_rw,
    output logic              rsp_ref,
    output logic              rsp_dirty,
    output logic              rsp_fault,
    input  logic              fill_valid,
    input  logic [VPN_W-1:0]  fill_vpn,
    input  logic [PPN_W-1:0]  fill_ppn,
    input  logic [ASID_W-1:0] fill_asid,
    input  logic              fill_rw,
    input  logic              inv_one,
    input  logic [VPN_W-1:0]  inv_vpn,
    input  logic [ASID_W-1:0] inv_asid,
    input  logic              inv_all
);

    // Entry storage.
    logic [ENTRIES-1:0]             e_valid;
    logic [ENTRIES-1:0][VPN_W-1:0]  e_vpn;
    logic [ENTRIES-1:0][PPN_W-1:0]  e_ppn;
    logic [ENTRIES-1:0][ASID_W-1:0] e_asid;
    logic [ENTRIES-1:0]             e_rw;
    logic [ENTRIES-1:0]             e_ref;
    logic [ENTRIES-1:0]             e_dirty;

    // Compare results.
    logic [ENTRIES-1:0] lk_hit_vec;
    logic [ENTRIES-1:0] fill_hit_vec;
    logic [ENTRIES-1:0] inv_hit_vec;
    logic               lk_any;
    logic [IDX_W-1:0]   lk_idx;
    logic               fill_any;
    logic [IDX_W-1:0]   fill_hit_idx;
    logic               free_any;
    logic [IDX_W-1:0]   free_idx;
    logic [IDX_W-1:0]   victim_idx;
    logic [IDX_W-1:0]   fill_idx;
    logic               fill_go;
    logic               lk_hit_go;

    xlat_match #(.N(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_lk_match (
        .ent_valid (e_valid),
        .ent_vpn   (e_vpn),
        .ent_asid  (e_asid),
        .key_vpn   (lk_vpn),
        .key_asid  (cur_asid),
        .hit_vec   (lk_hit_vec)
    );

    xlat_match #(.N(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_fill_match (
        .ent_valid (e_valid),
        .ent_vpn   (e_vpn),
        .ent_asid  (e_asid),
        .key_vpn   (fill_vpn),
        .key_asid  (fill_asid),
        .hit_vec   (fill_hit_vec)
    );

    xlat_match #(.N(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_inv_match (
        .ent_valid (e_valid),
        .ent_vpn   (e_vpn),
        .ent_asid  (e_asid),
        .key_vpn   (inv_vpn),
        .key_asid  (inv_asid),
        .hit_vec   (inv_hit_vec)
    );

    xlat_enc #(.N(ENTRIES)) u_lk_enc (
        .req (lk_hit_vec),
        .any (lk_any),
        .idx (lk_idx)
    );

    xlat_enc #(.N(ENTRIES)) u_fill_enc (
        .req (fill_hit_vec),
        .any (fill_any),
        .idx (fill_hit_idx)
    );

    xlat_enc #(.N(ENTRIES)) u_free_enc (
        .req (~e_valid),
        .any (free_any),
        .idx (free_idx)
    );

    // Request qualifiers.
    assign fill_go   = fill_valid && !inv_all;
    assign lk_hit_go = lk_valid && lk_any;

    // Slot choice: overwrite a duplicate, else a free slot, else the victim.
    always_comb begin
        if (fill_any)      fill_idx = fill_hit_idx;
        else if (free_any) fill_idx = free_idx;
        else               fill_idx = victim_idx;
    end

    xlat_plru #(.N(ENTRIES)) u_plru (
        .clk         (clk),
        .rst_n       (rst_n),
        .touch_a     (lk_hit_go),
        .touch_a_idx (lk_idx),
        .touch_b     (fill_go),
        .touch_b_idx (fill_idx),
        .victim_idx  (victim_idx)
    );

    // Per-entry state update in priority order.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        logic fill_here;
        assign fill_here = fill_go && (fill_idx == IDX_W'(g));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                e_valid[g] <= 1'b0;
                e_vpn[g]   <= '0;
                e_ppn[g]   <= '0;
                e_asid[g]  <= '0;
                e_rw[g]    <= 1'b0;
                e_ref[g]   <= 1'b0;
                e_dirty[g] <= 1'b0;
            end else if (inv_all) begin
                e_valid[g] <= 1'b0;
            end else if (inv_one && inv_hit_vec[g]) begin
                e_valid[g] <= 1'b0;
            end else if (fill_here) begin
                e_valid[g] <= 1'b1;
                e_vpn[g]   <= fill_vpn;
                e_ppn[g]   <= fill_ppn;
                e_asid[g]  <= fill_asid;
                e_rw[g]    <= fill_rw;
                e_ref[g]   <= 1'b0;
                e_dirty[g] <= 1'b0;
            end else if (lk_valid && lk_hit_vec[g]) begin
                e_ref[g] <= 1'b1;
                if (lk_write && (e_rw[g] == ACC_RW)) e_dirty[g] <= 1'b1;
            end
        end
    end

    // Registered lookup response; all fields zero on a miss.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_ppn   <= '0;
            rsp_rw    <= 1'b0;
            rsp_ref   <= 1'b0;
            rsp_dirty <= 1'b0;
            rsp_fault <= 1'b0;
        end else begin
            rsp_valid <= lk_valid;
            if (lk_hit_go) begin
                rsp_hit   <= 1'b1;
                rsp_ppn   <= e_ppn[lk_idx];
                rsp_rw    <= e_rw[lk_idx];
                rsp_ref   <= e_ref[lk_idx];
                rsp_dirty <= e_dirty[lk_idx];
                rsp_fault <= lk_write && (e_rw[lk_idx] == ACC_RO);
            end else begin
                rsp_hit   <= 1'b0;
                rsp_ppn   <= '0;
                rsp_rw    <= 1'b0;
                rsp_ref   <= 1'b0;
                rsp_dirty <= 1'b0;
                rsp_fault <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/xlat_cache_chk.sv
// Port-level protocol checks for xlat_cache, attached with bind.
// Assumes: connected by name to the top module's ports.
module xlat_cache_chk #(
    parameter int unsigned PPN_W = 20
) (
    input logic             clk,
    input logic             rst_n,
    input logic             lk_valid,
    input logic             inv_all,
    input logic             rsp_valid,
    input logic             rsp_hit,
    input logic [PPN_W-1:0] rsp_ppn,
    input logic             rsp_rw,
    input logic             rsp_ref,
    input logic             rsp_dirty,
    input logic             rsp_fault
);

    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n) lk_valid |=> rsp_valid); // R2
    AST_NO_RSP_UNASKED: assert property (@(posedge clk) disable iff (!rst_n) !lk_valid |=> !rsp_valid); // R2
    AST_FAULT_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n) rsp_fault |-> (rsp_valid && rsp_hit)); // R6
    AST_FAULT_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n) rsp_fault |-> !rsp_rw); // R6
    AST_DIRTY_WRITABLE: assert property (@(posedge clk) disable iff (!rst_n) rsp_dirty |-> rsp_rw); // R5
    AST_DIRTY_HAS_REF: assert property (@(posedge clk) disable iff (!rst_n) rsp_dirty |-> rsp_ref); // R4
    AST_MISS_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (rsp_valid && !rsp_hit) |-> (rsp_ppn == '0 && !rsp_fault && !rsp_dirty && !rsp_ref && !rsp_rw)); // R12
    AST_FLUSH_MISSES: assert property (@(posedge clk) disable iff (!rst_n) inv_all ##1 lk_valid |=> !rsp_hit); // R11

endmodule

bind xlat_cache xlat_cache_chk #(.PPN_W(PPN_W)) u_chk (.*);

// File: tb/tb_xlat_cache.sv
// Directed bench for xlat_cache: one task per scenario.
module tb_xlat_cache;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  cur_asid = '0;
    logic        lk_valid = 1'b0;
    logic [19:0] lk_vpn = '0;
    logic        lk_write = 1'b0;
    logic        rsp_valid, rsp_hit, rsp_rw, rsp_ref, rsp_dirty, rsp_fault;
    logic [19:0] rsp_ppn;
    logic        fill_valid = 1'b0;
    logic [19:0] fill_vpn = '0;
    logic [19:0] fill_ppn = '0;
    logic [7:0]  fill_asid = '0;
    logic        fill_rw = 1'b0;
    logic        inv_one = 1'b0;
    logic [19:0] inv_vpn = '0;
    logic [7:0]  inv_asid = '0;
    logic        inv_all = 1'b0;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    xlat_cache dut (
        .clk(clk), .rst_n(rst_n), .cur_asid(cur_asid),
        .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_write(lk_write),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_ppn(rsp_ppn),
        .rsp_rw(rsp_rw), .rsp_ref(rsp_ref), .rsp_dirty(rsp_dirty),
        .rsp_fault(rsp_fault),
        .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
        .fill_asid(fill_asid), .fill_rw(fill_rw),
        .inv_one(inv_one), .inv_vpn(inv_vpn), .inv_asid(inv_asid),
        .inv_all(inv_all)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_fill(input logic [19:0] vpn, input logic [19:0] ppn, input logic [7:0] asid, input logic rw);
        fill_valid = 1'b1; fill_vpn = vpn; fill_ppn = ppn; fill_asid = asid; fill_rw = rw;
        @(negedge clk);
        fill_valid = 1'b0;
    endtask

    task automatic do_inv_one(input logic [19:0] vpn, input logic [7:0] asid);
        inv_one = 1'b1; inv_vpn = vpn; inv_asid = asid;
        @(negedge clk);
        inv_one = 1'b0;
    endtask

    task automatic do_inv_all();
        inv_all = 1'b1;
        @(negedge clk);
        inv_all = 1'b0;
    endtask

    // Request at a falling edge; the registered response is sampled at the next one.
    task automatic do_lookup(input logic [19:0] vpn, input logic wr);
        lk_valid = 1'b1; lk_vpn = vpn; lk_write = wr;
        @(negedge clk);
        lk_valid = 1'b0; lk_write = 1'b0;
    endtask

    task automatic expect_hit(input string tag, input logic [19:0] vpn, input logic [19:0] ppn);
        do_lookup(vpn, 1'b0);
        chk(rsp_valid && rsp_hit && rsp_ppn == ppn, tag, {43'd0, rsp_hit, rsp_ppn}, {43'd0, 1'b1, ppn});
    endtask

    task automatic expect_miss(input string tag, input logic [19:0] vpn);
        do_lookup(vpn, 1'b0);
        chk(rsp_valid && !rsp_hit && rsp_ppn == '0 && !rsp_fault, tag,
            {42'd0, rsp_valid, rsp_hit, rsp_ppn}, {42'd0, 1'b1, 1'b0, 20'd0});
    endtask

    task automatic t_reset();
        chk(rsp_valid == 1'b0, "R1 rsp_valid after reset", 64'(rsp_valid), 64'd0);
        do_lookup(20'h5, 1'b0);
        chk(rsp_valid && !rsp_hit, "R1 lookup after reset misses", {62'd0, rsp_valid, rsp_hit}, 64'd2);
        chk(rsp_ppn == '0 && !rsp_rw && !rsp_ref && !rsp_dirty && !rsp_fault, "R12 miss fields zero",
            {40'd0, rsp_ppn, rsp_rw, rsp_ref, rsp_dirty, rsp_fault}, 64'd0);
    endtask

    task automatic t_basic_usage();
        cur_asid = 8'd1;
        do_fill(20'h12, 20'hABC, 8'd1, 1'b1);
        do_lookup(20'h12, 1'b0);
        chk(rsp_valid && rsp_hit && rsp_ppn == 20'hABC && rsp_rw, "R2 hit returns page and right",
            {41'd0, rsp_valid, rsp_hit, rsp_rw, rsp_ppn}, {41'd0, 3'b111, 20'hABC});
        chk(!rsp_ref && !rsp_dirty, "R4 fresh fill ref/dirty clear", {62'd0, rsp_ref, rsp_dirty}, 64'd0);
        do_lookup(20'h12, 1'b1);
        chk(rsp_ref && !rsp_dirty && !rsp_fault, "R4 second hit sees ref", {61'd0, rsp_ref, rsp_dirty, rsp_fault}, 64'd4);
        do_lookup(20'h12, 1'b0);
        chk(rsp_dirty && rsp_ref, "R5 write hit set dirty", {62'd0, rsp_ref, rsp_dirty}, 64'd3);
    endtask

    task automatic t_fault();
        do_fill(20'h20, 20'h55, 8'd1, 1'b0);
        do_lookup(20'h20, 1'b0);
        chk(rsp_hit && !rsp_fault && !rsp_rw, "R6 read of read-only no fault", {61'd0, rsp_hit, rsp_fault, rsp_rw}, 64'd4);
        do_lookup(20'h20, 1'b1);
        chk(rsp_hit && rsp_fault, "R6 write to read-only faults", {62'd0, rsp_hit, rsp_fault}, 64'd3);
        do_lookup(20'h20, 1'b0);
        chk(!rsp_dirty && rsp_ref, "R6 faulting write left entry clean", {62'd0, rsp_ref, rsp_dirty}, 64'd2);
    endtask

    task automatic t_asid();
        do_fill(20'h30, 20'h77, 8'd2, 1'b1);
        cur_asid = 8'd1;
        expect_miss("R3 other identifier misses", 20'h30);
        do_fill(20'h30, 20'h66, 8'd1, 1'b1);
        expect_hit("R3 identifier 1 page", 20'h30, 20'h66);
        cur_asid = 8'd2;
        expect_hit("R3 identifier 2 page", 20'h30, 20'h77);
        do_inv_one(20'h30, 8'd2);
        expect_miss("R10 targeted entry removed", 20'h30);
        cur_asid = 8'd1;
        expect_hit("R10 same page other identifier kept", 20'h30, 20'h66);
    endtask

    task automatic t_dedupe();
        do_inv_all();
        cur_asid = 8'd1;
        for (int i = 0; i < 16; i++) do_fill(20'h100 + 20'(i), 20'h200 + 20'(i), 8'd1, 1'b1);
        do_fill(20'h105, 20'h999, 8'd1, 1'b1);
        for (int i = 0; i < 16; i++) begin
            expect_hit("R7 refill kept all slots", 20'h100 + 20'(i), (i == 5) ? 20'h999 : 20'h200 + 20'(i));
        end
    endtask

    task automatic t_replace();
        do_inv_all();
        expect_miss("R11 global invalidate", 20'h100);
        expect_miss("R11 global invalidate other page", 20'h10F);
        for (int i = 0; i < 16; i++) do_fill(20'h300 + 20'(i), 20'h400 + 20'(i), 8'd1, 1'b1);
        // Tree after fills 0..15 points at slot 0; hitting slot 0 moves it to slot 8.
        expect_hit("R9 slot 0 present", 20'h300, 20'h400);
        do_fill(20'h3FF, 20'h4FF, 8'd1, 1'b1);
        expect_miss("R9 slot 8 evicted", 20'h308);
        expect_hit("R9 recently hit kept", 20'h300, 20'h400);
        expect_hit("R9 new fill present", 20'h3FF, 20'h4FF);
        expect_hit("R9 neighbour kept", 20'h309, 20'h409);
        // Touches so far leave the tree pointing at slot 4.
        do_fill(20'h3FE, 20'h4FE, 8'd1, 1'b1);
        expect_miss("R9 slot 4 evicted", 20'h304);
        // Punch a hole in slot 10; the next fill must use it.
        do_inv_one(20'h30A, 8'd1);
        expect_miss("R10 single invalidate", 20'h30A);
        do_fill(20'h3FD, 20'h4FD, 8'd1, 1'b1);
        for (int i = 0; i < 16; i++) begin
            if (i != 4 && i != 8 && i != 10)
                expect_hit("R8 free slot used before evicting", 20'h300 + 20'(i), 20'h400 + 20'(i));
        end
        expect_hit("R8 filled page present", 20'h3FD, 20'h4FD);
        expect_hit("R8 earlier fill kept", 20'h3FE, 20'h4FE);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic_usage();
        t_fault();
        t_asid();
        t_dedupe();
        t_replace();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule